// File: doc/BRIEF.md
# Settable 24-Hour Time-of-Day Keeper

This block keeps the time of day in hours, minutes and seconds. It runs from a 32.768 kHz watch-crystal clock. A binary prescaler turns that clock into one tick per second, and the tick advances a chain of three counters: seconds, then minutes, then hours. The hours wrap after 23, so the clock repeats every 24 hours.

Three active-high push-button inputs set the time, one for each field. Each button passes through a two-flop synchroniser and a stability filter. Every accepted press then adds one to its own field and to no other. Setting the seconds also restarts the prescaler, so the next tick comes a full second after the set. The outputs are the three binary fields and the tick itself. Seven-segment decoding and display scanning belong to a neighbouring block.

Top module: `tod_keeper`

## Requirements
- R1: `tick` is high for one cycle in every 2^PRESCALE_W clock cycles (32768 by default). With no set-second press, the first tick comes in the 2^PRESCALE_W-th cycle after reset is released.
- R2: On each tick, `seconds` goes up by one. A tick at 59 takes `seconds` to 0 and raises a carry into the minutes.
- R3: `minutes` goes up by one on a seconds carry. A carry at 59 takes `minutes` to 0 and raises a carry into the hours.
- R4: `hours` goes up by one on a minutes carry and goes from 23 to 0.
- R5: An accepted set-hour press adds one to `hours` and takes 23 to 0. It leaves `minutes` and `seconds` unchanged.
- R6: An accepted set-minute press adds one to `minutes` and takes 59 to 0. It never carries into `hours`.
- R7: An accepted set-second press adds one to `seconds` and takes 59 to 0. It never carries into `minutes`. It also restarts the prescaler, so the next tick comes 2^PRESCALE_W cycles later.
- R8: A button input is pressed when it is 1. A press is accepted once the synchronised level has differed from the accepted level for DEBOUNCE_CYCLES consecutive cycles (655, about 20 ms, by default). Shorter pulses are ignored. Each accepted rising level gives exactly one increment, however the contact bounces, and a release gives none.
- R9: If a set press and a tick or carry reach the same field in the same cycle, that field goes up by exactly one. A set-second press that coincides with a tick at 59 produces no minute carry.
- R10: `rst` is a synchronous, active-high reset. It clears the time to 00:00:00 and clears the prescaler, and `tick` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time base |
| rst | input | 1 | Synchronous active-high reset |
| btn_hour | input | 1 | Raw set-hour button, 1 = pressed |
| btn_min | input | 1 | Raw set-minute button, 1 = pressed |
| btn_sec | input | 1 | Raw set-second button, 1 = pressed |
| hours | output | 5 | Binary hour, 0..23 |
| minutes | output | 6 | Binary minute, 0..59 |
| seconds | output | 6 | Binary second, 0..59 |
| tick | output | 1 | One-cycle pulse once per second |

## Verification
The time fields are registered outputs, so a wrong internal count appears at the ports one cycle after the edge that produced it. A reference model that tracks the ports every cycle catches the error at that point. A prescaler that drifts by one cycle moves `tick`, and the fault is visible on the next expected tick. A missed or doubled carry appears at the next wrap of the field below it. A debounce filter that is too lenient or too strict moves or duplicates a field increment a few cycles after the button changes.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned SEC_MOD  = 60;
  localparam int unsigned MIN_MOD  = 60;
  localparam int unsigned HOUR_MOD = 24;

  // Modulo increment shared by every time field and its checks.
  function automatic logic [7:0] step_mod(input logic [7:0] v, input int unsigned m);
    logic [8:0] nxt;
    nxt = {1'b0, v} + 9'd1;
    return (nxt >= 9'(m)) ? 8'd0 : nxt[7:0];
  endfunction
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int unsigned PRESCALE_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic tick_o
);
  logic [PRESCALE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = &cnt_q;

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> !tick_o);
endmodule

// File: rtl/tod_button.sv
module tod_button #(
  parameter int unsigned DEBOUNCE_CYCLES = 655
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic press_o
);
  localparam int unsigned CW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

  logic       meta_q, sync_q, level_q, press_q;
  logic [CW-1:0] run_q;
  logic       accept;

  assign accept = (sync_q != level_q) && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q  <= 1'b0;
      sync_q  <= 1'b0;
      level_q <= 1'b0;
      run_q   <= '0;
      press_q <= 1'b0;
    end else begin
      meta_q  <= raw_i;
      sync_q  <= meta_q;
      press_q <= accept && sync_q;
      if (sync_q == level_q) begin
        run_q <= '0;
      end else if (accept) begin
        level_q <= sync_q;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign press_o = press_q;

  // R8
  press_once_chk: assert property (@(posedge clk) disable iff (rst)
    press_o |=> !press_o);
  // R8
  press_level_chk: assert property (@(posedge clk) disable iff (rst)
    press_o |-> level_q);
endmodule

// File: rtl/tod_field.sv
module tod_field
  import tod_pkg::*;
#(
  parameter int unsigned MODULUS = 60,
  parameter int unsigned W       = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  input  logic         set_i,
  output logic [W-1:0] value_o,
  output logic         carry_o
);
  logic [W-1:0] value_q;

  always_ff @(posedge clk) begin
    if (rst)                value_q <= '0;
    else if (set_i || adv_i) value_q <= W'(step_mod(8'(value_q), MODULUS));
  end

  // Carry only on a tick-driven wrap; a set never carries.
  assign carry_o = adv_i && !set_i && (value_q == W'(MODULUS - 1));
  assign value_o = value_q;

  // R2
  range_chk: assert property (@(posedge clk) disable iff (rst)
    value_q < W'(MODULUS));
  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i || adv_i) |=> value_q == W'(step_mod(8'($past(value_q)), MODULUS)));
  // R2
  carry_zero_chk: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> value_q == '0);
endmodule

// File: rtl/tod_keeper.sv
module tod_keeper
  import tod_pkg::*;
#(
  parameter int unsigned PRESCALE_W      = 15,
  parameter int unsigned DEBOUNCE_CYCLES = 655
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_hour,
  input  logic       btn_min,
  input  logic       btn_sec,
  output logic [4:0] hours,
  output logic [5:0] minutes,
  output logic [5:0] seconds,
  output logic       tick
);
  localparam int unsigned NBTN = 3;

  logic [NBTN-1:0] raw_btn, set_pulse;
  logic set_sec, set_min, set_hour;
  logic sec_tick, sec_carry, min_carry, hour_carry;

  assign raw_btn  = {btn_hour, btn_min, btn_sec};
  assign set_sec  = set_pulse[0];
  assign set_min  = set_pulse[1];
  assign set_hour = set_pulse[2];

  for (genvar i = 0; i < NBTN; i++) begin : g_btn
    tod_button #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_btn (
      .clk(clk), .rst(rst), .raw_i(raw_btn[i]), .press_o(set_pulse[i])
    );
  end

  tod_prescaler #(.PRESCALE_W(PRESCALE_W)) u_pre (
    .clk(clk), .rst(rst), .restart_i(set_sec), .tick_o(sec_tick)
  );

  tod_field #(.MODULUS(SEC_MOD), .W(6)) u_sec (
    .clk(clk), .rst(rst), .adv_i(sec_tick), .set_i(set_sec),
    .value_o(seconds), .carry_o(sec_carry)
  );
  tod_field #(.MODULUS(MIN_MOD), .W(6)) u_min (
    .clk(clk), .rst(rst), .adv_i(sec_carry), .set_i(set_min),
    .value_o(minutes), .carry_o(min_carry)
  );
  tod_field #(.MODULUS(HOUR_MOD), .W(5)) u_hour (
    .clk(clk), .rst(rst), .adv_i(min_carry), .set_i(set_hour),
    .value_o(hours), .carry_o(hour_carry)
  );

  assign tick = sec_tick;

  // R3
  min_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sec_carry |=> minutes == 6'(step_mod(8'($past(minutes)), MIN_MOD)));
  // R4
  hour_follow_chk: assert property (@(posedge clk) disable iff (rst)
    min_carry |=> hours == 5'(step_mod(8'($past(hours)), HOUR_MOD)));
  // R5
  hour_set_isolate_chk: assert property (@(posedge clk) disable iff (rst)
    (set_hour && !sec_tick && !set_sec && !set_min) |=> $stable(minutes) && $stable(seconds));
  // R9
  no_set_carry_chk: assert property (@(posedge clk) disable iff (rst)
    set_sec |-> !sec_carry);
  // R4
  day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    hour_carry |=> hours == 5'd0);
endmodule

// File: tb/tod_keeper_test.sv
`timescale 1ns/1ps
module tod_keeper_test;
  localparam int PW  = 4;
  localparam int PER = 1 << PW;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] raw = 3'b000;   // 0 sec, 1 min, 2 hour
  logic [4:0] hours;
  logic [5:0] minutes, seconds;
  logic tick;

  always #2.5 clk = ~clk;

  tod_keeper #(.PRESCALE_W(PW), .DEBOUNCE_CYCLES(DEB)) uut (
    .clk(clk), .rst(rst), .btn_hour(raw[2]), .btn_min(raw[1]), .btn_sec(raw[0]),
    .hours(hours), .minutes(minutes), .seconds(seconds), .tick(tick)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // Behavioural reference model
  int m_sec, m_min, m_hr, m_pc;
  int s0[3], s1[3], lv[3], run[3], pl[3];

  task automatic model_clear();
    m_sec = 0; m_min = 0; m_hr = 0; m_pc = 0;
    for (int i = 0; i < 3; i++) begin
      s0[i] = 0; s1[i] = 0; lv[i] = 0; run[i] = 0; pl[i] = 0;
    end
  endtask

  initial model_clear();

  always @(posedge clk) begin
    cyc++;
    if (rst) model_clear();
    else begin
      int tk, csec, cmin, np;
      tk = (m_pc == PER - 1);
      csec = tk && !pl[0] && m_sec == 59;
      if (pl[0]) begin m_sec = (m_sec + 1) % 60; m_pc = 0; end
      else begin
        if (tk) m_sec = (m_sec + 1) % 60;
        m_pc = (m_pc + 1) % PER;
      end
      cmin = csec && !pl[1] && m_min == 59;
      if (pl[1] || csec) m_min = (m_min + 1) % 60;
      if (pl[2] || cmin) m_hr = (m_hr + 1) % 24;
      for (int i = 0; i < 3; i++) begin
        np = 0;
        if (s1[i] != lv[i]) begin
          if (run[i] == DEB - 1) begin np = s1[i]; lv[i] = s1[i]; run[i] = 0; end
          else run[i]++;
        end else run[i] = 0;
        pl[i] = np;
        s1[i] = s0[i];
        s0[i] = int'(raw[i]);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1/R7 tick", int'(tick), int'(m_pc == PER - 1));
      chk("R2/R7/R9 seconds", int'(seconds), m_sec);
      chk("R3/R6/R9 minutes", int'(minutes), m_min);
      chk("R4/R5/R9 hours", int'(hours), m_hr);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(int idx, int hold, int gap);
    @(negedge clk); raw[idx] = 1'b1;
    idle(hold);
    raw[idx] = 1'b0;
    idle(gap);
  endtask

  initial begin
    int first, h0;
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R10: state right after reset
    chk("R10 hours", int'(hours), 0);
    chk("R10 minutes", int'(minutes), 0);
    chk("R10 seconds", int'(seconds), 0);
    chk("R10 tick", int'(tick), 0);
    // R1: first tick after 2^PW - 1 further edges
    first = 0;
    for (int i = 1; i <= PER; i++) begin
      @(negedge clk);
      if (tick && first == 0) first = i;
    end
    chk("R1 first tick cycle", first, PER - 1);
    // R8: bouncing press on set-hour gives one increment
    h0 = int'(hours);
    for (int i = 0; i < 8; i++) begin @(negedge clk); raw[2] = ~raw[2]; end
    @(negedge clk); raw[2] = 1'b1;
    idle(12);
    for (int i = 0; i < 6; i++) begin @(negedge clk); raw[2] = ~raw[2]; end
    @(negedge clk); raw[2] = 1'b0;
    idle(12);
    chk("R8 bounce one increment", int'(hours), h0 + 1);
    // R8: short glitch is ignored
    @(negedge clk); raw[2] = 1'b1;
    idle(2);
    raw[2] = 1'b0;
    idle(14);
    chk("R8 glitch ignored", int'(hours), h0 + 1);
    // R5/R6: set fields to 23:59 by presses
    while (m_hr != 23) press(2, 8, 8);
    while (m_min != 59) press(1, 8, 8);
    chk("R5 hour preset", int'(hours), 23);
    // R7/R9: set-second presses at varying offsets, including wrap
    for (int k = 0; k < 20; k++) press(0, 7 + (k % 5), 6 + (k % 7));
    while (m_sec < 55) press(0, 8, 8);
    // R2/R3/R4: natural rollover 23:59:59 -> 00:00:00
    while (!(m_hr == 0 && m_min == 0)) @(negedge clk);
    chk("R4 day wrap hours", int'(hours), 0);
    chk("R3 day wrap minutes", int'(minutes), 0);
    // R6: minute press at 59 does not carry into hours
    while (m_min != 59) press(1, 8, 8);
    h0 = m_hr;
    press(1, 8, 8);
    chk("R6 no carry hours", int'(hours), h0);
    idle(3 * PER);
    // R10: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 rerun hours", int'(hours), 0);
    chk("R10 rerun seconds", int'(seconds), 0);
    chk("R10 rerun tick", int'(tick), 0);
    idle(40);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule